// File: doc/BRIEF.md
# Buffered Serial Byte Transmitter with Demand-Started Bit Clock

This block sends 8-bit bytes as asynchronous serial frames on a single output line. A frame is a low start bit, then the eight data bits with the least significant bit first, then a high stop bit. It has no parity. The block holds one byte in a holding register in front of a frame shifter. This lets software queue the next byte while the current one is still on the wire.

The block does not time the bits itself. A separate bit-timing unit delivers a one-cycle `bit_tick` pulse once per bit period. The block drives a run request, `rate_run`, that switches that unit on and off. The request rises when a byte is written. It falls when a frame ends and no byte is waiting. The bit timer therefore only runs while there is data to send.

A software hold input keeps the whole transmitter idle. Raising it in the middle of a frame aborts the frame at once.

Top module: `buffered_serial_tx`

## Requirements
- R1: While `sw_hold` is 1, from the following cycle on: `txd` is 1, `buf_empty` is 1 and `rate_run` is 0. A write in that time leaves all three unchanged.
- R2: After `sw_hold` falls with no write, the block is idle: `txd` is 1, `buf_empty` is 1 and `rate_run` is 0. A `bit_tick` in this state changes none of them.
- R3: One cycle after a write strobe (with `sw_hold` at 0), `buf_empty` is 0 and `rate_run` is 1.
- R4: When the shifter is empty, the first `bit_tick` moves the pending byte into the shifter. One cycle later `txd` is 0 (the start bit) and `buf_empty` is 1.
- R5: Each later `bit_tick` advances the line by exactly one bit: data bit 0 through data bit 7, then a stop bit of 1. Without a tick, `txd` holds its value.
- R6: If a byte is pending when the tick that ends the stop bit arrives, that same tick loads the byte. `txd` is 0 in the next cycle, with no idle bit in between.
- R7: If no byte is pending at that tick, `txd` returns to 1 and `rate_run` falls to 0 in the next cycle.
- R8: A write while the holding register is full replaces the pending byte. `buf_empty` stays 0, and the later byte is the one sent.
- R9: Raising `sw_hold` during a frame aborts it. In the next cycle `txd` is 1, `buf_empty` is 1 (any pending byte is dropped) and `rate_run` is 0.
- R10: A write in the same cycle as a loading tick keeps the new byte pending (`buf_empty` 0) while the old byte starts its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_hold | input | 1 | Software hold: 1 keeps the transmitter idle and aborts any frame |
| wr_stb | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Byte to queue |
| bit_tick | input | 1 | One-cycle pulse per bit period from the bit-timing unit |
| txd | output | 1 | Serial output line, idles high |
| buf_empty | output | 1 | Interrupt flag: the holding register can take a byte |
| rate_run | output | 1 | Request that enables the bit-timing unit |

## Verification
The failures that matter are a wrong bit index and a lost pending flag. A wrong bit index shows at `txd` within one tick period, as a misplaced data bit or stop bit. A lost pending flag shows at the end of the frame, as an idle high bit where a start bit belongs, or as a run request that stays high after the last frame. A wrong order between writes, loads and hold shows at `buf_empty` one cycle after the event that caused it. So each frame is checked bit by bit, and the flag and the run request are sampled in the cycle after each write, load, frame end and abort.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (hold) begin
      valid <= 1'b0;
    end else if (wr_stb) begin
      valid <= 1'b1;
      data  <= wr_data;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
  import tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              bit_tick,
  input  logic              pend_valid,
  input  logic [DATA_W-1:0] pend_data,
  output logic              take,
  output logic              frame_end,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  tx_state_e          state;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  shreg;
  logic               at_last;

  function automatic logic frame_bit(input logic [DATA_W-1:0] d,
                                     input logic [IDX_W-1:0] i);
    int k;
    k = int'(i);
    if (k == 0) return 1'b0;
    else if (k <= DATA_W) return d[k-1];
    else return 1'b1;
  endfunction

  assign at_last   = (state == ST_SEND) && (idx == LAST_IDX);
  assign frame_end = bit_tick && !hold && at_last;
  assign take      = bit_tick && !hold && pend_valid && ((state == ST_IDLE) || at_last);
  assign busy      = (state == ST_SEND);
  assign txd       = busy ? frame_bit(shreg, idx) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      shreg <= '0;
    end else if (hold) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (take) begin
      state <= ST_SEND;
      idx   <= '0;
      shreg <= pend_data;
    end else if (frame_end) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (bit_tick && busy) begin
      idx <= idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/tx_rate_gate.sv
module tx_rate_gate (
  input  logic pend_valid,
  input  logic busy,
  output logic rate_run
);
  assign rate_run = pend_valid | busy;
endmodule

// File: rtl/buffered_serial_tx.sv
module buffered_serial_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_hold,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_tick,
  output logic              txd,
  output logic              buf_empty,
  output logic              rate_run
);
  logic              pend_valid;
  logic [DATA_W-1:0] pend_data;
  logic              load_evt;
  logic              frame_end;
  logic              busy;

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .hold(sw_hold), .wr_stb(wr_stb),
    .wr_data(wr_data), .take(load_evt), .valid(pend_valid), .data(pend_data)
  );

  tx_frame_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .hold(sw_hold), .bit_tick(bit_tick),
    .pend_valid(pend_valid), .pend_data(pend_data), .take(load_evt),
    .frame_end(frame_end), .busy(busy), .txd(txd)
  );

  tx_rate_gate u_gate (
    .pend_valid(pend_valid), .busy(busy), .rate_run(rate_run)
  );

  assign buf_empty = !pend_valid;
endmodule

// File: rtl/tx_checker.sv
module tx_checker (
  input logic clk,
  input logic rst_n,
  input logic sw_hold,
  input logic wr_stb,
  input logic bit_tick,
  input logic txd,
  input logic buf_empty,
  input logic rate_run,
  input logic load_evt,
  input logic frame_end
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hold |=> (txd && buf_empty && !rate_run)); // R1
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !sw_hold) |=> (!buf_empty && rate_run)); // R3
  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_stb) |=> buf_empty); // R4
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !txd); // R4
  AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !sw_hold) |=> $stable(txd)); // R5
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !buf_empty) |=> !txd); // R6
  AST_IDLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && buf_empty && !wr_stb) |=> (txd && !rate_run)); // R7
  AST_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && wr_stb) |=> !buf_empty); // R10
endmodule

bind buffered_serial_tx tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sw_hold(sw_hold), .wr_stb(wr_stb),
  .bit_tick(bit_tick), .txd(txd), .buf_empty(buf_empty),
  .rate_run(rate_run), .load_evt(load_evt), .frame_end(frame_end)
);

// File: tb/sim_buffered_serial_tx.sv
module sim_buffered_serial_tx;
  localparam int NV = 6;
  // {chain next entry into this frame, data byte}
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 8'hA5}, {1'b1, 8'h00}, {1'b0, 8'hFF},
    {1'b0, 8'h01}, {1'b1, 8'h80}, {1'b0, 8'h3C}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_hold = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit_tick = 1'b0;
  logic       txd, buf_empty, rate_run;
  int         checks = 0;
  int         errs = 0;
  bit         loaded;

  always #5 clk = ~clk;

  buffered_serial_tx #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_hold(sw_hold), .wr_stb(wr_stb),
    .wr_data(wr_data), .bit_tick(bit_tick), .txd(txd),
    .buf_empty(buf_empty), .rate_run(rate_run)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // data bits then stop bit of a frame already started
  task automatic frame_body(input logic [7:0] d);
    for (int b = 0; b < 8; b++) begin
      do_tick();
      chk($sformatf("R5 data bit %0d of %0h", b, d), txd, d[b]);
    end
    do_tick();
    chk("R5 stop bit", txd, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset buf_empty", buf_empty, 1'b1);
    chk("R1 reset rate_run", rate_run, 1'b0);
    do_write(8'h5A);
    chk("R1 write under hold buf_empty", buf_empty, 1'b1);
    chk("R1 write under hold rate_run", rate_run, 1'b0);
    @(negedge clk); sw_hold = 1'b0;
    @(negedge clk);
    chk("R2 idle txd", txd, 1'b1);
    chk("R2 idle rate_run", rate_run, 1'b0);
    do_tick();
    chk("R2 tick no data txd", txd, 1'b1);
    chk("R2 tick no data buf_empty", buf_empty, 1'b1);

    // table walk
    loaded = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [7:0] d;
      logic chain;
      d = VEC[i][7:0];
      chain = VEC[i][8];
      if (!loaded) begin
        do_write(d);
        chk("R3 write buf_empty", buf_empty, 1'b0);
        chk("R3 write rate_run", rate_run, 1'b1);
        do_tick();
        chk("R4 load start bit", txd, 1'b0);
        chk("R4 load buf_empty", buf_empty, 1'b1);
      end
      if (chain) do_write(VEC[(i + 1) % NV][7:0]);
      frame_body(d);
      do_tick();
      if (chain) begin
        chk("R6 back-to-back start", txd, 1'b0);
        chk("R6 rate_run held", rate_run, 1'b1);
        loaded = 1'b1;
      end else begin
        chk("R7 idle txd", txd, 1'b1);
        chk("R7 rate_run off", rate_run, 1'b0);
        loaded = 1'b0;
      end
    end

    // R8: overwrite pending byte
    do_write(8'hA5);
    do_write(8'h3C);
    chk("R8 overwrite buf_empty", buf_empty, 1'b0);
    do_tick();
    chk("R8 start bit", txd, 1'b0);
    frame_body(8'h3C);
    do_tick();
    chk("R8 idle after", rate_run, 1'b0);

    // R10: write in the loading cycle
    do_write(8'h11);
    @(negedge clk); bit_tick = 1'b1; wr_stb = 1'b1; wr_data = 8'h22;
    @(negedge clk); bit_tick = 1'b0; wr_stb = 1'b0;
    chk("R10 new byte pending", buf_empty, 1'b0);
    chk("R10 old byte start", txd, 1'b0);
    repeat (2) @(negedge clk);
    frame_body(8'h11);
    do_tick();
    chk("R10 chained start", txd, 1'b0);
    frame_body(8'h22);
    do_tick();
    chk("R10 idle txd", txd, 1'b1);

    // R9: abort mid-frame with a byte pending
    do_write(8'hF0);
    do_tick();
    do_tick();
    chk("R9 pre-abort data bit", txd, 1'b0);
    do_write(8'h55);
    @(negedge clk); sw_hold = 1'b1;
    @(negedge clk);
    chk("R9 abort txd", txd, 1'b1);
    chk("R9 abort buf_empty", buf_empty, 1'b1);
    chk("R9 abort rate_run", rate_run, 1'b0);
    sw_hold = 1'b0;
    do_tick();
    chk("R9 dropped byte not sent", txd, 1'b1);
    chk("R9 run stays off", rate_run, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule